// File: doc/BRIEF.md
# Status Flag Manipulation Unit

This block keeps the 8-bit status word of a small 8-bit core and carries out the single-bit operations on it. It can set or clear any one flag, chosen by its index. It can copy one chosen bit of a register value into the transfer flag T, and it can write T back into one chosen bit of a register value. It also handles the two conditional branches that test the global interrupt-enable flag I. For these it works out whether the branch is taken, the next program counter and the number of cycles used.

The decoder supplies an operation code together with the operands in one cycle. The register-value output, the next PC, the taken strobe and the cycle count are combinational. They depend on the inputs and on the status word as it stands before the clock edge. The status word changes on the clock edge that ends the operation. Status bits, from bit 7 down to bit 0, are I, T, H, S, V, N, Z, C.

Top module: `flag_unit`

## Requirements
- R1: While rst_ni is low, sreg_o is 8'h00. Reset is asynchronous and active low.
- R2: op_i=1 (flag set) drives status bit flag_idx_i to 1 at the next clock edge and leaves the other seven bits unchanged. Index 0 is C, 1 Z, 2 N, 3 V, 4 S, 5 H, 6 T and 7 I, so this one operation also serves as the dedicated single-cycle set for each named flag.
- R3: op_i=2 (flag clear) drives status bit flag_idx_i to 0 at the next clock edge and leaves the other seven bits unchanged.
- R4: op_i=3 (bit store) copies reg_val_i[bit_idx_i] into T (status bit 6) at the next clock edge. No other status bit changes.
- R5: op_i=4 (bit load) drives reg_val_o with reg_val_i, except that bit bit_idx_i is replaced by the current T. The status word does not change.
- R6: op_i=5 branches when I (bit 7) is 1, and op_i=6 branches when I is 0. A taken branch raises taken_o and gives next_pc_o = pc_i + sign-extended 7-bit offset_i + 1, modulo 2^PC_W.
- R7: When no branch is taken (any op other than a taken branch), next_pc_o = pc_i + 1 modulo 2^PC_W and taken_o = 0.
- R8: cycles_o is 2 for a taken branch and 1 for every other operation.
- R9: op_i=0, both branch ops and the unused codes 7 to 15 leave the status word unchanged.
- R10: For every op other than bit load, reg_val_o equals reg_val_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| flag_idx_i | input | 3 | Status bit index for flag set and flag clear |
| reg_val_i | input | 8 | Register operand value |
| bit_idx_i | input | 3 | Bit index within the register operand |
| offset_i | input | 7 | Two's-complement branch offset |
| pc_i | input | PC_W | Current program counter |
| sreg_o | output | 8 | Status word (I T H S V N Z C) |
| reg_val_o | output | 8 | Register value after a bit load |
| next_pc_o | output | PC_W | Next program counter |
| taken_o | output | 1 | Branch taken |
| cycles_o | output | 2 | Cycles used by the operation |

## Verification
On every cycle the assertions check the following:
- after flag set, flag clear and bit store, only the addressed status bit has moved;
- the operations that must leave the status word alone do so;
- the cycle count matches the taken strobe;
- a branch op whose condition holds is reported as taken;
- every op other than bit load passes the register value straight through.

Only the bench's scenarios can show the exact arithmetic of the target address. These scenarios cover forward and backward offsets and a wrap past the top of the PC range. The bench scenarios are also the only check that bit load picks up T as left by an earlier bit store. Finally, they sweep every flag index through set and clear.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;
  localparam int unsigned SREG_W = 8;
  localparam int unsigned SIDX_W = $clog2(SREG_W);
  localparam int unsigned FLAG_T = 6;
  localparam int unsigned FLAG_I = 7;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_FSET  = 4'd1,
    OP_FCLR  = 4'd2,
    OP_BST   = 4'd3,
    OP_BLD   = 4'd4,
    OP_BR_IE = 4'd5,
    OP_BR_ID = 4'd6
  } op_e;
endpackage

// File: rtl/flag_reg.sv
module flag_reg
  import flag_unit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [SIDX_W-1:0] flag_idx_i,
  input  logic              src_bit_i,
  output logic [SREG_W-1:0] sreg_o
);
  logic [SREG_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    case (op_i)
      OP_FSET: sreg_d[flag_idx_i] = 1'b1;
      OP_FCLR: sreg_d[flag_idx_i] = 1'b0;
      OP_BST:  sreg_d[FLAG_T]     = src_bit_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else         sreg_q <= sreg_d;
  end

  assign sreg_o = sreg_q;
endmodule

// File: rtl/bit_xfer.sv
module bit_xfer #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BIDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [BIDX_W-1:0] bit_idx_i,
  input  logic              t_flag_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] reg_val_o,
  output logic              src_bit_o
);
  assign src_bit_o = reg_val_i[bit_idx_i];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign reg_val_o[i] = (load_i && (bit_idx_i == BIDX_W'(i))) ? t_flag_i : reg_val_i[i];
  end
endmodule

// File: rtl/branch_calc.sv
module branch_calc
  import flag_unit_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 7
) (
  input  logic [3:0]       op_i,
  input  logic             i_flag_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             taken_o,
  output logic [1:0]       cycles_o
);
  logic [PC_W-1:0] off_ext, pc_inc;

  assign off_ext = {{(PC_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign pc_inc  = pc_i + PC_W'(1);

  always_comb begin
    case (op_i)
      OP_BR_IE: taken_o = i_flag_i;
      OP_BR_ID: taken_o = ~i_flag_i;
      default:  taken_o = 1'b0;
    endcase
  end

  assign next_pc_o = taken_o ? (pc_inc + off_ext) : pc_inc;
  assign cycles_o  = taken_o ? 2'd2 : 2'd1;
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_unit_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [SIDX_W-1:0] flag_idx_i,
  input  logic [7:0]        reg_val_i,
  input  logic [2:0]        bit_idx_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [SREG_W-1:0] sreg_o,
  output logic [7:0]        reg_val_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic [1:0]        cycles_o
);
  logic src_bit;
  logic is_load;

  assign is_load = (op_i == OP_BLD);

  bit_xfer #(.DATA_W(8)) u_xfer (
    .reg_val_i (reg_val_i),
    .bit_idx_i (bit_idx_i),
    .t_flag_i  (sreg_o[FLAG_T]),
    .load_i    (is_load),
    .reg_val_o (reg_val_o),
    .src_bit_o (src_bit)
  );

  flag_reg u_sreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op_i),
    .flag_idx_i (flag_idx_i),
    .src_bit_i  (src_bit),
    .sreg_o     (sreg_o)
  );

  branch_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_br (
    .op_i      (op_i),
    .i_flag_i  (sreg_o[FLAG_I]),
    .offset_i  (offset_i),
    .pc_i      (pc_i),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o),
    .cycles_o  (cycles_o)
  );
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flag_unit_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [SIDX_W-1:0] flag_idx_i,
  input logic [7:0]        reg_val_i,
  input logic [2:0]        bit_idx_i,
  input logic [SREG_W-1:0] sreg_o,
  input logic [7:0]        reg_val_o,
  input logic              taken_o,
  input logic [1:0]        cycles_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> sreg_o == '0);

  assert_set_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FSET) |=> sreg_o[$past(flag_idx_i)] == 1'b1);

  assert_set_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FSET) |=>
      ((sreg_o ^ $past(sreg_o)) & ~(SREG_W'(1) << $past(flag_idx_i))) == '0);

  assert_clr_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FCLR) |=> sreg_o[$past(flag_idx_i)] == 1'b0);

  assert_clr_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FCLR) |=>
      ((sreg_o ^ $past(sreg_o)) & ~(SREG_W'(1) << $past(flag_idx_i))) == '0);

  assert_bst_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BST) |=> sreg_o[FLAG_T] == $past(reg_val_i[bit_idx_i]));

  assert_bst_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BST) |=> (sreg_o & 8'hBF) == ($past(sreg_o) & 8'hBF));

  assert_bld_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BLD) |=> $stable(sreg_o));

  assert_br_ie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_BR_IE) && sreg_o[FLAG_I]) |-> taken_o);

  assert_br_id_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_BR_ID) && !sreg_o[FLAG_I]) |-> taken_o);

  assert_no_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((op_i == OP_BR_IE) || (op_i == OP_BR_ID)) |-> !taken_o);

  assert_cycles_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycles_o == (taken_o ? 2'd2 : 2'd1));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_NOP) || (op_i == OP_BR_IE) || (op_i == OP_BR_ID) || (op_i > 4'd6))
      |=> $stable(sreg_o));

  assert_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_BLD) |-> reg_val_o == reg_val_i);
endmodule

bind flag_unit flag_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .flag_idx_i (flag_idx_i),
  .reg_val_i  (reg_val_i),
  .bit_idx_i  (bit_idx_i),
  .sreg_o     (sreg_o),
  .reg_val_o  (reg_val_o),
  .taken_o    (taken_o),
  .cycles_o   (cycles_o)
);

// File: tb/tb_flag_unit.sv
module tb_flag_unit;
  localparam int PC_W = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [3:0]      op_i = '0;
  logic [2:0]      flag_idx_i = '0;
  logic [7:0]      reg_val_i = '0;
  logic [2:0]      bit_idx_i = '0;
  logic [6:0]      offset_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic [7:0]      sreg_o, reg_val_o;
  logic [PC_W-1:0] next_pc_o;
  logic            taken_o;
  logic [1:0]      cycles_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  flag_unit #(.PC_W(PC_W)) dut (.*);

  typedef struct packed {
    logic [3:0]  op;
    logic [2:0]  fidx;
    logic [7:0]  rval;
    logic [2:0]  bidx;
    logic [6:0]  off;
    logic [15:0] pc;
    logic [7:0]  e_sreg;
    logic [7:0]  e_rv;
    logic [15:0] e_pc;
    logic [1:0]  e_cyc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 3'd7, 8'h5A, 3'd0, 7'h00, 16'h0010, 8'h80, 8'h5A, 16'h0011, 2'd1},
    '{4'd5, 3'd0, 8'h5A, 3'd0, 7'h05, 16'h0100, 8'h80, 8'h5A, 16'h0106, 2'd2},
    '{4'd6, 3'd0, 8'h5A, 3'd0, 7'h05, 16'h0100, 8'h80, 8'h5A, 16'h0101, 2'd1},
    '{4'd5, 3'd0, 8'h11, 3'd0, 7'h7E, 16'h0100, 8'h80, 8'h11, 16'h00FF, 2'd2},
    '{4'd3, 3'd0, 8'h04, 3'd2, 7'h00, 16'h0200, 8'hC0, 8'h04, 16'h0201, 2'd1},
    '{4'd4, 3'd0, 8'h00, 3'd7, 7'h00, 16'h0300, 8'hC0, 8'h80, 16'h0301, 2'd1},
    '{4'd2, 3'd7, 8'h00, 3'd0, 7'h00, 16'h0300, 8'h40, 8'h00, 16'h0301, 2'd1},
    '{4'd6, 3'd0, 8'h00, 3'd0, 7'h3F, 16'h0010, 8'h40, 8'h00, 16'h0050, 2'd2},
    '{4'd5, 3'd0, 8'h00, 3'd0, 7'h3F, 16'h0010, 8'h40, 8'h00, 16'h0011, 2'd1},
    '{4'd1, 3'd0, 8'h00, 3'd0, 7'h00, 16'h0020, 8'h41, 8'h00, 16'h0021, 2'd1},
    '{4'd3, 3'd0, 8'hFB, 3'd2, 7'h00, 16'h0020, 8'h01, 8'hFB, 16'h0021, 2'd1},
    '{4'd4, 3'd0, 8'hFF, 3'd3, 7'h00, 16'h0020, 8'h01, 8'hF7, 16'h0021, 2'd1},
    '{4'd15,3'd2, 8'h33, 3'd1, 7'h10, 16'h0040, 8'h01, 8'h33, 16'h0041, 2'd1},
    '{4'd1, 3'd3, 8'h00, 3'd0, 7'h00, 16'h0040, 8'h09, 8'h00, 16'h0041, 2'd1},
    '{4'd2, 3'd0, 8'h00, 3'd0, 7'h00, 16'h0040, 8'h08, 8'h00, 16'h0041, 2'd1},
    '{4'd6, 3'd0, 8'h00, 3'd0, 7'h00, 16'hFFFF, 8'h08, 8'h00, 16'h0000, 2'd2}
  };

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk_i);
    op_i = v.op; flag_idx_i = v.fidx; reg_val_i = v.rval;
    bit_idx_i = v.bidx; offset_i = v.off; pc_i = v.pc;
    #2;
    check((v.op == 4'd4) ? "R5" : "R10", 32'(reg_val_o), 32'(v.e_rv));
    check((v.e_cyc == 2'd2) ? "R6" : "R7", 32'(next_pc_o), 32'(v.e_pc));
    check("R8", 32'(cycles_o), 32'(v.e_cyc));
    @(posedge clk_i); #1;
    check(tag_of(v.op), 32'(sreg_o), 32'(v.e_sreg));
  endtask

  task automatic flag_op(logic [3:0] op, int idx, logic [7:0] exp);
    @(negedge clk_i);
    op_i = op; flag_idx_i = 3'(idx); pc_i = 16'h0500;
    @(posedge clk_i); #1;
    check((op == 4'd1) ? "R2" : "R3", 32'(sreg_o), 32'(exp));
  endtask

  initial begin
    #1 check("R1", 32'(sreg_o), 32'h0);
    repeat (2) @(posedge clk_i);
    #1 check("R1", 32'(sreg_o), 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // walk every flag index through set, then clear
    begin
      logic [7:0] m = 8'h08;
      for (int i = 0; i < 8; i++) begin m[i] = 1'b1; flag_op(4'd1, i, m); end
      for (int i = 0; i < 8; i++) begin m[i] = 1'b0; flag_op(4'd2, i, m); end
      for (int i = 0; i < 8; i++) begin m[i] = 1'b1; flag_op(4'd1, i, m); end
    end

    // asynchronous reset mid-run, R1
    @(negedge clk_i);
    op_i = 4'd0;
    rst_ni = 1'b0;
    #1 check("R1", 32'(sreg_o), 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1 check("R1", 32'(sreg_o), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule